// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Counter

This block keeps a free-running time of day made of a 48-bit seconds count, a 30-bit nanoseconds count and a 16-bit sub-nanosecond fraction. On every clock cycle it adds a fixed-point step to that time. The step is the nominal period, which has 4 whole-nanosecond bits above 16 fractional bits. When the nanoseconds part reaches one second, it rolls over into the seconds count.

Two correction paths change the step. The drift corrector adds a small fractional value once every N cycles, which trims the long-term rate more finely than the period's least significant bit allows. The slew corrector replaces the nominal period with a second period for a programmed number of cycles. This moves the time by a bounded offset without a jump, and its cycle counter reads back as zero once the slew is over.

A host programs the block through single-cycle write strobes, each with its own data fields. It can also load an absolute time. The current time, the remaining slew cycles and the clock frequency in Hz are always present on parallel outputs.

Top module: `tod_counter`

## Requirements
- R1: Synchronous active-high reset clears seconds, nanoseconds, fraction and the remaining slew count to zero. It disables drift correction and loads the nominal period from parameter DEF_PERIOD (default 4.0 ns, 0x40000).
- R2: On each clock edge without a time load, the value {nanoseconds, fraction} grows by the active step, in units of 2^-16 ns. When the sum reaches 1,000,000,000 ns, that amount is subtracted. Nanoseconds therefore always stay below 1,000,000,000.
- R3: Each rollover adds one to the 48-bit seconds count, which wraps from 2^48-1 to 0.
- R4: A period write (period_we) does not alter the time. The edge that captures the write still uses the old period, and the following edges use the new one.
- R5: A slew write loads a period and a cycle count. While the count is non-zero, the slew period replaces the nominal period, and the count falls by one per edge. slew_left shows the count and reads zero once the slew is finished.
- R6: With drift interval N non-zero, drift_frac (in 2^-16 ns) is added to the step on every Nth edge. The first addition comes N edges after the edge that captured the drift write. N = 0 adds nothing.
- R7: Each drift write restarts the interval count, even when N is unchanged.
- R8: A time load sets seconds and nanoseconds from its data, clears the fraction, and replaces that edge's advance. Slew and drift counters keep running on that edge.
- R9: clk_freq_hz always shows parameter CLK_HZ (default 250,000,000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| time_we | input | 1 | Load absolute time strobe |
| time_sec | input | 48 | Seconds to load |
| time_ns | input | 30 | Nanoseconds to load, below 10^9 |
| period_we | input | 1 | Nominal period write strobe |
| period_val | input | 20 | Nominal period, 4.16 fixed-point ns |
| slew_we | input | 1 | Slew write strobe |
| slew_period | input | 20 | Period used while slewing, 4.16 ns |
| slew_cycles | input | 20 | Number of slew cycles |
| drift_we | input | 1 | Drift write strobe |
| drift_frac | input | 16 | Drift increment in 2^-16 ns |
| drift_every | input | 16 | Drift interval N in cycles, 0 disables |
| tod_sec | output | 48 | Seconds count |
| tod_ns | output | 30 | Nanoseconds count |
| tod_frac | output | 16 | Sub-nanosecond fraction |
| slew_left | output | 20 | Remaining slew cycles |
| clk_freq_hz | output | 32 | Counter clock frequency in Hz |

## Verification
The time, fraction and slew count are registers. A strobe driven before a rising edge therefore shows its effect on that same edge, and a new period takes hold one edge later. A drift write shows its first addition N edges after its capture edge. The bench drives inputs on the falling edge. It advances its own model on each rising edge and compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. Directed checks of second rollover, seconds wrap, slew completion and drift restart use the same sampling point.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;
endpackage

// File: rtl/tod_slew.sv
module tod_slew #(
  parameter int PERIOD_W = 20,
  parameter int CNT_W    = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                slew_we,
  input  logic [PERIOD_W-1:0] slew_period,
  input  logic [CNT_W-1:0]    slew_cycles,
  input  logic [PERIOD_W-1:0] nominal,
  output logic [PERIOD_W-1:0] active_period,
  output logic [CNT_W-1:0]    slew_left
);
  logic [PERIOD_W-1:0] per_q;
  logic [CNT_W-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (slew_we) begin
      per_q <= slew_period;
      cnt_q <= slew_cycles;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_period = (cnt_q != '0) ? per_q : nominal;
  assign slew_left     = cnt_q;

  // R5: an active slew counts down by exactly one per cycle
  a_r5_slew_countdown: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !slew_we) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R5: an idle slew stays idle until written
  a_r5_slew_idle: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !slew_we) |=> (cnt_q == '0));
endmodule

// File: rtl/tod_drift.sv
module tod_drift #(
  parameter int FRAC_W = 16,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drift_we,
  input  logic [FRAC_W-1:0] drift_frac,
  input  logic [RATE_W-1:0] drift_every,
  output logic [FRAC_W-1:0] drift_add
);
  logic [RATE_W-1:0] rate_q;
  logic [RATE_W-1:0] phase_q;
  logic [FRAC_W-1:0] frac_q;
  logic              hit;

  assign hit = (rate_q != '0) && (phase_q == rate_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q  <= '0;
      phase_q <= '0;
      frac_q  <= '0;
    end else if (drift_we) begin
      rate_q  <= drift_every;
      frac_q  <= drift_frac;
      phase_q <= '0;
    end else if (rate_q != '0) begin
      phase_q <= hit ? '0 : phase_q + 1'b1;
    end
  end

  assign drift_add = hit ? frac_q : '0;

  // R6: the interval phase never reaches the interval length
  a_r6_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    (rate_q != '0) |-> (phase_q < rate_q));
  // R7: a drift write restarts the interval
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    drift_we |=> (phase_q == '0));
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int FRAC_W = 16,
  parameter int STEP_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_we,
  input  logic [SEC_W-1:0]  load_sec,
  input  logic [NS_W-1:0]   load_ns,
  input  logic [STEP_W-1:0] step,
  output logic [SEC_W-1:0]  sec,
  output logic [NS_W-1:0]   ns,
  output logic [FRAC_W-1:0] frac
);
  localparam int ACC_W = NS_W + FRAC_W;
  localparam logic [ACC_W:0] LIMIT = (ACC_W+1)'(tod_pkg::NS_PER_SEC) << FRAC_W;
  localparam logic [NS_W-1:0] NS_MAX = NS_W'(tod_pkg::NS_PER_SEC);

  logic [ACC_W-1:0] acc_q;
  logic [SEC_W-1:0] sec_q;
  logic [ACC_W:0]   sum;
  logic             wrap;

  always_comb begin
    sum  = {1'b0, acc_q} + (ACC_W+1)'(step);
    wrap = (sum >= LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      sec_q <= '0;
    end else if (load_we) begin
      acc_q <= {load_ns, {FRAC_W{1'b0}}};
      sec_q <= load_sec;
    end else begin
      acc_q <= wrap ? ACC_W'(sum - LIMIT) : sum[ACC_W-1:0];
      sec_q <= sec_q + SEC_W'(wrap);
    end
  end

  assign sec  = sec_q;
  assign ns   = acc_q[ACC_W-1:FRAC_W];
  assign frac = acc_q[FRAC_W-1:0];

  // R2: nanoseconds stay below one second
  a_r2_ns_below_second: assert property (@(posedge clk) disable iff (rst)
    ns < NS_MAX);
  // R3: seconds move by at most one per cycle unless loaded
  a_r3_sec_step: assert property (@(posedge clk) disable iff (rst)
    !load_we |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + SEC_W'(1)));
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int          SEC_W      = 48,
  parameter int          NS_W       = 30,
  parameter int          FRAC_W     = 16,
  parameter int          PERIOD_W   = 20,
  parameter int          CNT_W      = 20,
  parameter int          RATE_W     = 16,
  parameter int unsigned CLK_HZ     = 250_000_000,
  parameter int unsigned DEF_PERIOD = 32'h0004_0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                time_we,
  input  logic [SEC_W-1:0]    time_sec,
  input  logic [NS_W-1:0]     time_ns,
  input  logic                period_we,
  input  logic [PERIOD_W-1:0] period_val,
  input  logic                slew_we,
  input  logic [PERIOD_W-1:0] slew_period,
  input  logic [CNT_W-1:0]    slew_cycles,
  input  logic                drift_we,
  input  logic [FRAC_W-1:0]   drift_frac,
  input  logic [RATE_W-1:0]   drift_every,
  output logic [SEC_W-1:0]    tod_sec,
  output logic [NS_W-1:0]     tod_ns,
  output logic [FRAC_W-1:0]   tod_frac,
  output logic [CNT_W-1:0]    slew_left,
  output logic [31:0]         clk_freq_hz
);
  localparam int STEP_W = PERIOD_W + 1;

  logic [PERIOD_W-1:0] period_q;
  logic [PERIOD_W-1:0] active_period;
  logic [FRAC_W-1:0]   drift_add;
  logic [STEP_W-1:0]   step;

  always_ff @(posedge clk) begin
    if (rst)            period_q <= PERIOD_W'(DEF_PERIOD);
    else if (period_we) period_q <= period_val;
  end

  // R4: the nominal period only changes on a period write
  a_r4_period_kept: assert property (@(posedge clk) disable iff (rst)
    !period_we |=> $stable(period_q));

  tod_slew #(.PERIOD_W(PERIOD_W), .CNT_W(CNT_W)) u_slew (
    .clk(clk), .rst(rst), .slew_we(slew_we), .slew_period(slew_period),
    .slew_cycles(slew_cycles), .nominal(period_q),
    .active_period(active_period), .slew_left(slew_left)
  );

  tod_drift #(.FRAC_W(FRAC_W), .RATE_W(RATE_W)) u_drift (
    .clk(clk), .rst(rst), .drift_we(drift_we), .drift_frac(drift_frac),
    .drift_every(drift_every), .drift_add(drift_add)
  );

  assign step = STEP_W'(active_period) + STEP_W'(drift_add);

  tod_accum #(.SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_accum (
    .clk(clk), .rst(rst), .load_we(time_we), .load_sec(time_sec), .load_ns(time_ns),
    .step(step), .sec(tod_sec), .ns(tod_ns), .frac(tod_frac)
  );

  assign clk_freq_hz = 32'(CLK_HZ);
endmodule

// File: tb/tb_tod_counter.sv
`timescale 1ns/1ps
module tb_tod_counter;
  localparam longint unsigned LIM = 64'd1_000_000_000 << 16;

  logic clk = 0;
  logic rst = 1;
  logic time_we = 0, period_we = 0, slew_we = 0, drift_we = 0;
  logic [47:0] time_sec = '0;
  logic [29:0] time_ns = '0;
  logic [19:0] period_val = '0, slew_period = '0, slew_cycles = '0;
  logic [15:0] drift_frac = '0, drift_every = '0;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;
  logic [15:0] tod_frac;
  logic [19:0] slew_left;
  logic [31:0] clk_freq_hz;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  tod_counter dut (
    .clk(clk), .rst(rst), .time_we(time_we), .time_sec(time_sec), .time_ns(time_ns),
    .period_we(period_we), .period_val(period_val), .slew_we(slew_we),
    .slew_period(slew_period), .slew_cycles(slew_cycles), .drift_we(drift_we),
    .drift_frac(drift_frac), .drift_every(drift_every), .tod_sec(tod_sec),
    .tod_ns(tod_ns), .tod_frac(tod_frac), .slew_left(slew_left), .clk_freq_hz(clk_freq_hz)
  );

  // Expected state, advanced on each rising edge from the requirements
  longint unsigned m_acc, m_sec;
  int unsigned m_per, m_sper, m_scnt, m_df, m_rate, m_ph;

  always @(posedge clk) begin
    longint unsigned st, s;
    if (rst) begin
      m_acc = 0; m_sec = 0; m_per = 32'h40000; m_sper = 0; m_scnt = 0;
      m_df = 0; m_rate = 0; m_ph = 0;
    end else begin
      st = (m_scnt != 0) ? m_sper : m_per;
      if (m_rate != 0 && m_ph == m_rate - 1) st += m_df;
      if (time_we) begin
        m_sec = time_sec; m_acc = longint'(time_ns) << 16;
      end else begin
        s = m_acc + st;
        if (s >= LIM) begin s -= LIM; m_sec = (m_sec + 1) & 48'hFFFF_FFFF_FFFF; end
        m_acc = s;
      end
      if (slew_we) begin m_sper = slew_period; m_scnt = slew_cycles; end
      else if (m_scnt != 0) m_scnt--;
      if (period_we) m_per = period_val;
      if (drift_we) begin m_df = drift_frac; m_rate = drift_every; m_ph = 0; end
      else if (m_rate != 0) m_ph = (m_ph == m_rate - 1) ? 0 : m_ph + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "sec", tod_sec, m_sec);
    chk(cur_req, "ns", tod_ns, m_acc >> 16);
    chk(cur_req, "frac", tod_frac, m_acc & 16'hFFFF);
    chk(cur_req, "slew_left", slew_left, m_scnt);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    compare_all();
    time_we = 0; period_we = 0; slew_we = 0; drift_we = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    @(posedge clk); @(negedge clk);
    // R1: reset state
    chk("R1", "reset sec", tod_sec, 0);
    chk("R1", "reset ns", tod_ns, 0);
    chk("R1", "reset slew_left", slew_left, 0);
    chk("R9", "clk_freq_hz", clk_freq_hz, 250_000_000);
    rst = 0;
    cur_req = "R1"; run(10);
    chk("R1", "default period 4ns x10", tod_ns, 40);

    // R2: rollover into seconds
    cur_req = "R8"; time_we = 1; time_sec = 48'd7; time_ns = 30'd999_999_996; tick();
    chk("R8", "loaded ns", tod_ns, 999_999_996);
    cur_req = "R2"; tick();
    chk("R2", "rollover ns", tod_ns, 0);
    chk("R3", "rollover sec", tod_sec, 7 + 1);
    run(5);

    // R3: seconds wrap
    cur_req = "R3"; time_we = 1; time_sec = 48'hFFFF_FFFF_FFFF; time_ns = 30'd999_999_998; tick();
    tick();
    chk("R3", "sec wrap", tod_sec, 0);
    chk("R3", "ns after wrap", tod_ns, 2);

    // R4: period change mid-run
    cur_req = "R4"; period_we = 1; period_val = 20'h2_8000; tick(); run(8);

    // R5: slew completes and reads zero
    cur_req = "R5"; slew_we = 1; slew_period = 20'hA_0000; slew_cycles = 20'd6; tick();
    chk("R5", "slew loaded", slew_left, 6);
    run(6);
    chk("R5", "slew done", slew_left, 0);
    run(3);

    // R6: drift disabled with zero interval, then enabled
    cur_req = "R6"; drift_we = 1; drift_frac = 16'h1234; drift_every = 16'd0; tick(); run(10);
    drift_we = 1; drift_every = 16'd4; tick(); run(13);

    // R7: rewriting the interval restarts it
    cur_req = "R7"; drift_we = 1; drift_every = 16'd4; tick(); run(2);
    drift_we = 1; drift_every = 16'd4; tick(); run(9);

    // random mix
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 3) begin
        cur_req = "R8"; time_we = 1; time_sec = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
        time_ns = 30'($urandom % 1_000_000_000);
      end else if (r < 6) begin
        cur_req = "R4"; period_we = 1; period_val = 20'h1_0000 + 20'($urandom % 20'hE_0000);
      end else if (r < 9) begin
        cur_req = "R5"; slew_we = 1; slew_period = 20'($urandom); slew_cycles = 20'($urandom % 40);
      end else if (r < 12) begin
        cur_req = "R6"; drift_we = 1; drift_frac = 16'($urandom); drift_every = 16'($urandom % 12);
      end
      tick();
    end
    chk("R9", "clk_freq_hz end", clk_freq_hz, 250_000_000);

    done = 1;
    summary();
    $finish;
  end
endmodule